// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps the local time for packet timestamping: a 48-bit seconds count and a 30-bit nanoseconds count that always stays below one billion. On every clock cycle it advances by a programmable rate. The rate has two parts: whole nanoseconds (8 bits) and a 24-bit fraction of a nanosecond. The fraction feeds an internal accumulator. Each time the accumulator overflows, one extra nanosecond is added. This lets the counter follow a clock whose period is not a whole number of nanoseconds. When nanoseconds reach one billion, they roll over into the seconds count.

Software reaches the block through a small register bus with word addresses 0 to 5. It can read a consistent time: the nanoseconds read also captures the seconds. It can load a new time, change the rate and apply a signed step correction. Several writes are staged so that multi-word updates land together. The high seconds word waits for the low seconds word, and the fraction waits for the whole-nanosecond rate. The current time is also driven out on the ports, where timestamp capture logic can sample it.

Top module: `ptp_tod_counter`

## Requirements
- R1: While reset is high, and after it is released with no writes, `tod_sec`, `tod_ns`, both active rate fields and `bus_rdata` are zero.
- R2: Each cycle with no time write or accepted step, the 24-bit fraction accumulator adds the active fraction. `tod_ns` then grows by the active whole-nanosecond rate plus the accumulator's carry-out.
- R3: When the nanosecond sum reaches 1,000,000,000, that amount is subtracted and `tod_sec` (48 bits) increments. `tod_ns` never holds a value of 1,000,000,000 or more.
- R4: A write to the fraction register (address 4) only stages the value. It becomes active on the next write to the whole-nanosecond rate register (address 3, bits 7:0). The fraction field layout is: register bits 15:0 carry fraction bits 23:8, and register bits 31:24 carry fraction bits 7:0.
- R5: A write to the seconds-high register (address 2, bits 15:0) leaves `tod_sec` unchanged. A write to the seconds-low register (address 1) loads the staged high word and the written low word into `tod_sec` together. In that cycle `tod_ns` keeps counting, but a rollover does not reach the seconds.
- R6: A write to the nanoseconds register (address 0) with a value below 1,000,000,000 loads `tod_ns` and clears the fraction accumulator, and the counter does not advance in that cycle. A larger value is ignored.
- R7: A write to the step register (address 5) adds the magnitude in bits 29:0 to `tod_ns` once, or subtracts it when bit 31 is set. An overflow carries into `tod_sec`, and an underflow borrows one second and adds 1,000,000,000.
- R8: A step with a magnitude of 1,000,000,000 or more is ignored.
- R9: With both active rate fields at zero, the time stays frozen.
- R10: A read of address 0 returns the nanoseconds and copies `tod_sec` into a shadow register. Reads of addresses 1 and 2 return the shadow's low 32 bits and high 16 bits. Read data appears on `bus_rdata` one cycle after the read strobe. Address 3 returns the active whole-nanosecond rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |

## Verification
Writes to the time, step and rate registers take effect at the clock edge that samples the strobe, so `tod_ns` and `tod_sec` show the new value in the half cycle after it. A newly committed rate first advances the time at the following edge. The bench therefore counts exactly K edges after the commit and predicts `N + K*rate + floor(K*fraction/2^24)`, normalised to seconds. Read data is registered once, and the bench samples it at the falling edge right after the strobed edge. All stimulus changes and all samples fall on falling edges.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

    localparam int SEC_W  = 48;
    localparam int NS_W   = 30;
    localparam int RATE_W = 8;
    localparam int FRAC_W = 24;

    localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

    typedef enum logic [2:0] {
        A_NSEC   = 3'd0,
        A_SEC_LO = 3'd1,
        A_SEC_HI = 3'd2,
        A_RATE   = 3'd3,
        A_FRAC   = 3'd4,
        A_STEP   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

    // register bits 15:0 -> fraction 23:8, register bits 31:24 -> fraction 7:0
    function automatic logic [FRAC_W-1:0] frac_unpack(input logic [31:0] w);
        return {w[15:0], w[31:24]};
    endfunction

    function automatic logic [31:0] frac_pack(input logic [FRAC_W-1:0] f);
        return {f[7:0], 8'h00, f[23:8]};
    endfunction

endpackage

// File: rtl/ptp_tod_rate.sv
module ptp_tod_rate
    import ptp_tod_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_rate,
    input  logic          wr_frac,
    input  logic [31:0]   wdata,
    input  logic          adv_en,
    input  logic          frac_clr,
    output logic [RW:0]   step_ns,
    output logic [RW-1:0] rate_ns
);
    logic [FW-1:0] frac_stage_q;
    logic [FW-1:0] frac_act_q;
    logic [RW-1:0] rate_q;
    logic [FW-1:0] acc_q;
    logic [FW:0]   acc_sum;

    assign acc_sum = {1'b0, acc_q} + {1'b0, frac_act_q};
    assign step_ns = {1'b0, rate_q} + {{RW{1'b0}}, acc_sum[FW]};
    assign rate_ns = rate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_stage_q <= '0;
            frac_act_q   <= '0;
            rate_q       <= '0;
        end else begin
            if (wr_frac)
                frac_stage_q <= frac_unpack(wdata)[FW-1:0];
            if (wr_rate) begin
                rate_q     <= wdata[RW-1:0];
                frac_act_q <= frac_stage_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || frac_clr)
            acc_q <= '0;
        else if (adv_en)
            acc_q <= acc_sum[FW-1:0];
    end

    // R4
    frac_stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_frac && !wr_rate) |=> $stable(frac_act_q));

endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
    import ptp_tod_pkg::*;
#(
    parameter int RW = RATE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_ns,
    input  logic [NS_W-1:0] ld_ns_val,
    input  logic            ld_sec,
    input  logic [SEC_W-1:0] ld_sec_val,
    input  logic            step_go,
    input  logic            step_neg,
    input  logic [NS_W-1:0] step_mag,
    input  logic            adv_en,
    input  logic [RW:0]     step_ns,
    output tod_t            tod
);
    tod_t         cur_q;
    tod_t         nxt;
    logic [NS_W:0] tick_sum;
    logic [NS_W:0] adj_sum;
    logic [NS_W:0] adj_dif;

    assign tick_sum = {1'b0, cur_q.ns} + {{(NS_W-RW){1'b0}}, step_ns};
    assign adj_sum  = {1'b0, cur_q.ns} + {1'b0, step_mag};
    assign adj_dif  = {1'b0, cur_q.ns} - {1'b0, step_mag};

    always_comb begin
        nxt = cur_q;
        if (ld_ns) begin
            nxt.ns = ld_ns_val;
        end else if (step_go) begin
            if (!step_neg) begin
                if (adj_sum >= {1'b0, NS_PER_SEC}) begin
                    nxt.ns  = adj_sum[NS_W-1:0] - NS_PER_SEC;
                    nxt.sec = cur_q.sec + 1'b1;
                end else begin
                    nxt.ns = adj_sum[NS_W-1:0];
                end
            end else begin
                if (adj_dif[NS_W]) begin
                    nxt.ns  = adj_dif[NS_W-1:0] + NS_PER_SEC;
                    nxt.sec = cur_q.sec - 1'b1;
                end else begin
                    nxt.ns = adj_dif[NS_W-1:0];
                end
            end
        end else if (adv_en) begin
            if (tick_sum >= {1'b0, NS_PER_SEC}) begin
                nxt.ns = tick_sum[NS_W-1:0] - NS_PER_SEC;
                if (!ld_sec)
                    nxt.sec = cur_q.sec + 1'b1;
            end else begin
                nxt.ns = tick_sum[NS_W-1:0];
            end
        end
        if (ld_sec && !ld_ns && !step_go)
            nxt.sec = ld_sec_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else
            cur_q <= nxt;
    end

    assign tod = cur_q;

    // R3
    ns_range_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.ns < NS_PER_SEC);

    // R3
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !ld_sec && !ld_ns && !step_go) |=>
        (cur_q.sec == $past(cur_q.sec) || cur_q.sec == $past(cur_q.sec) + 1'b1));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && step_ns == '0 && !ld_sec && !ld_ns && !step_go) |=>
        ($stable(cur_q.ns) && $stable(cur_q.sec)));

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_tod_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [47:0] tod_sec,
    output logic [29:0] tod_ns
);
    localparam int HI_W = SEC_W - 32;

    reg_addr_e          addr;
    logic               ld_ns;
    logic               ld_sec;
    logic               step_go;
    logic               adv_en;
    logic               wr_rate;
    logic               wr_frac;
    logic [RATE_W:0]    step_ns;
    logic [RATE_W-1:0]  rate_ns;
    logic [HI_W-1:0]    sec_hi_stage_q;
    logic [SEC_W-1:0]   shadow_q;
    logic [31:0]        rdata_q;
    tod_t               tod;

    assign addr    = reg_addr_e'(bus_addr);
    assign ld_ns   = bus_wr && addr == A_NSEC && bus_wdata < {2'b00, NS_PER_SEC};
    assign ld_sec  = bus_wr && addr == A_SEC_LO;
    assign step_go = bus_wr && addr == A_STEP && bus_wdata[NS_W-1:0] < NS_PER_SEC;
    assign wr_rate = bus_wr && addr == A_RATE;
    assign wr_frac = bus_wr && addr == A_FRAC;
    assign adv_en  = !ld_ns && !step_go;

    ptp_tod_rate #(.RW(RATE_W), .FW(FRAC_W)) u_rate (
        .clk      (clk),
        .rst      (rst),
        .wr_rate  (wr_rate),
        .wr_frac  (wr_frac),
        .wdata    (bus_wdata),
        .adv_en   (adv_en),
        .frac_clr (ld_ns),
        .step_ns  (step_ns),
        .rate_ns  (rate_ns)
    );

    ptp_tod_core #(.RW(RATE_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ld_ns      (ld_ns),
        .ld_ns_val  (bus_wdata[NS_W-1:0]),
        .ld_sec     (ld_sec),
        .ld_sec_val ({sec_hi_stage_q, bus_wdata}),
        .step_go    (step_go),
        .step_neg   (bus_wdata[31]),
        .step_mag   (bus_wdata[NS_W-1:0]),
        .adv_en     (adv_en),
        .step_ns    (step_ns),
        .tod        (tod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_hi_stage_q <= '0;
            shadow_q       <= '0;
            rdata_q        <= '0;
        end else begin
            if (bus_wr && addr == A_SEC_HI)
                sec_hi_stage_q <= bus_wdata[HI_W-1:0];
            if (bus_rd) begin
                case (addr)
                    A_NSEC: begin
                        rdata_q  <= {{(32-NS_W){1'b0}}, tod.ns};
                        shadow_q <= tod.sec;
                    end
                    A_SEC_LO: rdata_q <= shadow_q[31:0];
                    A_SEC_HI: rdata_q <= {{(32-HI_W){1'b0}}, shadow_q[SEC_W-1:32]};
                    A_RATE:   rdata_q <= {{(32-RATE_W){1'b0}}, rate_ns};
                    default:  rdata_q <= '0;
                endcase
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign tod_sec   = tod.sec;
    assign tod_ns    = tod.ns;

    // R10
    shadow_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && addr == A_NSEC) |=> (shadow_q == $past(tod_sec)));

    // R5
    sec_hi_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && addr == A_SEC_HI && step_ns == '0) |=> $stable(tod_sec));

endmodule

// File: tb/ptp_tod_counter_bench.sv
module ptp_tod_counter_bench;
    localparam longint BILLION = 64'd1_000_000_000;
    localparam int NV = 6;
    localparam logic [7:0]  V_RATE [NV] = '{8'd8, 8'd7, 8'd40, 8'd0, 8'd3, 8'd1};
    localparam logic [23:0] V_FRAC [NV] = '{24'h0, 24'h800000, 24'h0, 24'h0, 24'h555555, 24'h0};
    localparam logic [29:0] V_NS   [NV] = '{30'd100, 30'd0, 30'd999_999_900, 30'd500, 30'd1000, 30'd999_999_999};
    localparam logic [47:0] V_SEC  [NV] = '{48'd5, 48'd0, 48'h1234_5678_9ABC, 48'd7, 48'd1, 48'h0000_FFFF_FFFF};
    localparam int          V_CYC  [NV] = '{10, 4, 3, 20, 6, 1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [47:0] tod_sec;
    logic [29:0] tod_ns;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    ptp_tod_counter u_ptp_tod_counter (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tod_sec(tod_sec), .tod_ns(tod_ns)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] fpack(input logic [23:0] f);
        return {f[7:0], 8'h00, f[23:8]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        longint tot;
        logic [47:0] s0;
        repeat (3) @(negedge clk);
        check("R1 sec in reset", tod_sec, 0);
        check("R1 ns in reset", tod_ns, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 ns after reset", tod_ns, 0);
        check("R1 sec after reset", tod_sec, 0);
        check("R1 rdata after reset", bus_rdata, 0);
        rd(3'd3);
        check("R1 rate after reset", bus_rdata, 0);

        // table walk: R2 R3 R9
        for (int i = 0; i < NV; i++) begin
            wr(3'd4, 32'h0);
            wr(3'd3, 32'h0);
            wr(3'd0, 32'h0);
            wr(3'd2, {16'h0, V_SEC[i][47:32]});
            wr(3'd1, V_SEC[i][31:0]);
            wr(3'd0, {2'b00, V_NS[i]});
            wr(3'd4, fpack(V_FRAC[i]));
            wr(3'd3, {24'h0, V_RATE[i]});
            repeat (V_CYC[i]) @(negedge clk);
            tot = longint'(V_NS[i]) + longint'(V_CYC[i]) * longint'(V_RATE[i])
                + ((longint'(V_CYC[i]) * longint'(V_FRAC[i])) >> 24);
            check("R2/R3 vector ns", tod_ns, tot % BILLION);
            check("R2/R3 vector sec", tod_sec, longint'(V_SEC[i]) + tot / BILLION);
        end

        // R9 freeze
        wr(3'd4, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'd500);
        repeat (5) @(negedge clk);
        check("R9 frozen ns", tod_ns, 500);

        // R4 staged fraction has no effect until commit
        wr(3'd4, fpack(24'hFFFFFF));
        repeat (5) @(negedge clk);
        check("R4 staged fraction inactive", tod_ns, 500);
        wr(3'd4, 32'h0);

        // R5 seconds high staged
        s0 = tod_sec;
        wr(3'd2, 32'h22);
        check("R5 high write no effect", tod_sec, s0);
        wr(3'd1, 32'h33);
        check("R5 low write loads both", tod_sec, 48'h22_0000_0033);

        // R7 steps
        wr(3'd5, 32'd300);
        check("R7 positive step", tod_ns, 800);
        wr(3'd5, 32'h8000_0000 | 32'd900);
        check("R7 borrow ns", tod_ns, 999_999_900);
        check("R7 borrow sec", tod_sec, 48'h22_0000_0032);
        wr(3'd5, 32'd200);
        check("R7 carry ns", tod_ns, 100);
        check("R7 carry sec", tod_sec, 48'h22_0000_0033);

        // R8 oversized step ignored
        wr(3'd5, 32'd1_000_000_000);
        check("R8 oversized add ignored", tod_ns, 100);
        wr(3'd5, 32'h8000_0000 | 32'd1_000_000_000);
        check("R8 oversized sub ignored", tod_ns, 100);
        check("R8 sec untouched", tod_sec, 48'h22_0000_0033);

        // R6 nanosecond load
        wr(3'd0, 32'd1_000_000_000);
        check("R6 oversized load ignored", tod_ns, 100);
        wr(3'd0, 32'd12345);
        check("R6 load", tod_ns, 12345);

        // R10 coherent read
        rd(3'd0);
        check("R10 ns read", bus_rdata, 12345);
        wr(3'd1, 32'h99);
        check("R5 sec reloaded", tod_sec, 48'h22_0000_0099);
        rd(3'd1);
        check("R10 shadow low", bus_rdata, 32'h33);
        rd(3'd2);
        check("R10 shadow high", bus_rdata, 32'h22);

        // R2 fraction layout, rate read back
        wr(3'd0, 32'd0);
        wr(3'd4, fpack(24'h400000));
        wr(3'd3, 32'd2);
        repeat (8) @(negedge clk);
        check("R2 quarter fraction", tod_ns, 18);
        rd(3'd3);
        check("R10 rate read", bus_rdata, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule